// File: doc/BRIEF.md
# Integer Add, Subtract and Compare Unit

This block is a purely combinational integer unit for one execution lane of a RISC-style datapath. Each cycle it takes two operands, a 5-bit operation code, a trap-enable bit and a destination register number. It returns the operation's result, an integer-overflow trap flag, and the destination register number that accompanies that trap.

The unit performs full-width ("quadword") and low-half ("longword") addition and subtraction. Each has a plain form, an overflow-checked form, and forms that scale operand A by 4 or by 8 before the add or subtract. Longword results are sign-extended from bit LW-1 up to the full width. The unit also performs five comparisons, each of which returns exactly 0 or 1. An overflow in a checked form does not stop the result: the wrapped value is still written, and the trap flag is raised together with the register tag.

The widths are parameters: W is the operand width (64 by default), LW is the longword width (32 by default) and RW is the register-number width (5 by default).

Top module: `iu_addcmp`

## Requirements
- R1: The operation codes are 1 ADD_Q, 2 ADD_QV, 3 ADD4_Q, 4 ADD8_Q, 5 ADD_L, 6 ADD_LV, 7 ADD4_L, 8 ADD8_L, 9 SUB_Q, 10 SUB_QV, 11 SUB4_Q, 12 SUB8_Q, 13 SUB_L, 14 SUB_LV, 15 SUB4_L, 16 SUB8_L, 17 CMP_EQ, 18 CMP_LT, 19 CMP_LE, 20 CMP_ULT and 21 CMP_ULE. The V suffix marks the overflow-checked forms.
- R2: ADD_Q, ADD_QV, SUB_Q and SUB_QV return A+B or A-B modulo 2^W.
- R3: The scaled forms first shift A left by 2 (the 4 forms) or by 3 (the 8 forms), discard the bits shifted out, and then add or subtract B modulo 2^W.
- R4: Every longword form (codes 5-8 and 13-16) returns the W-bit sum or difference with bits W-1..LW copied from bit LW-1.
- R5: CMP_EQ tests A==B. CMP_LT and CMP_LE use signed two's-complement order. CMP_ULT and CMP_ULE use unsigned order. Each comparison returns 1 when true and 0 when false, and all other result bits are 0.
- R6: ADD_QV overflows when A[W-1]==B[W-1] and the result's bit W-1 differs from A[W-1].
- R7: SUB_QV overflows when A[W-1]!=B[W-1] and the result's bit W-1 differs from A[W-1].
- R8: ADD_LV and SUB_LV apply the sign tests of R6 and R7 at bit LW-1, using the sign-extended result.
- R9: When a trap is raised, res_o still carries the wrapped result and trap_dst_o equals dst_i. When no trap is raised, trap_dst_o is 0.
- R10: Operations other than ADD_QV, SUB_QV, ADD_LV and SUB_LV never raise ovf_trap_o, whatever the operands.
- R11: When trap_en_i is 0, ovf_trap_o stays 0 for every operation.
- R12: Codes 0 and 22-31 are unused. They return a result of 0 and raise no trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | W | Operand A |
| opb_i | input | W | Operand B |
| op_i | input | 5 | Operation code (R1) |
| trap_en_i | input | 1 | Enables the overflow trap for checked forms |
| dst_i | input | RW | Destination register number |
| res_o | output | W | Result |
| ovf_trap_o | output | 1 | Integer-overflow trap |
| trap_dst_o | output | RW | Register tag of the trap, 0 when there is no trap |

## Verification
The bench builds the unit twice.

The first copy uses W=6, LW=3 and RW=3. At that size every operand pair can be swept against every one of the 32 codes. This exhaustively reaches every carry, sign and longword-boundary combination, including scaled operands whose shifted-out bits matter.

The second copy uses the default W=64, LW=32 and RW=5. It is driven with corner operands (0, 1, -1, the most negative and most positive values, and the values on both sides of the longword sign boundary) and with random pairs.

Both copies are checked against a reference that computes exact signed sums in 128 bits.

// File: rtl/iu_pkg.sv
package iu_pkg;

    typedef enum logic [4:0] {
        OP_NONE    = 5'd0,
        OP_ADD_Q   = 5'd1,
        OP_ADD_QV  = 5'd2,
        OP_ADD4_Q  = 5'd3,
        OP_ADD8_Q  = 5'd4,
        OP_ADD_L   = 5'd5,
        OP_ADD_LV  = 5'd6,
        OP_ADD4_L  = 5'd7,
        OP_ADD8_L  = 5'd8,
        OP_SUB_Q   = 5'd9,
        OP_SUB_QV  = 5'd10,
        OP_SUB4_Q  = 5'd11,
        OP_SUB8_Q  = 5'd12,
        OP_SUB_L   = 5'd13,
        OP_SUB_LV  = 5'd14,
        OP_SUB4_L  = 5'd15,
        OP_SUB8_L  = 5'd16,
        OP_CMP_EQ  = 5'd17,
        OP_CMP_LT  = 5'd18,
        OP_CMP_LE  = 5'd19,
        OP_CMP_ULT = 5'd20,
        OP_CMP_ULE = 5'd21
    } iu_op_e;

    typedef enum logic [2:0] {
        CMP_EQ  = 3'd0,
        CMP_LT  = 3'd1,
        CMP_LE  = 3'd2,
        CMP_ULT = 3'd3,
        CMP_ULE = 3'd4
    } iu_cmp_e;

    typedef struct packed {
        logic       valid;
        logic       is_cmp;
        logic       sub;
        logic [1:0] shamt;
        logic       longw;
        logic       chk;
        iu_cmp_e    cmp;
    } iu_ctl_t;

endpackage

// File: rtl/iu_decode.sv
module iu_decode
    import iu_pkg::*;
(
    input  logic [4:0] op_i,
    output iu_ctl_t    ctl_o
);

    always_comb begin
        ctl_o       = '0;
        ctl_o.valid = 1'b1;
        ctl_o.cmp   = CMP_EQ;
        unique case (op_i)
            OP_ADD_Q:   ;
            OP_ADD_QV:  ctl_o.chk = 1'b1;
            OP_ADD4_Q:  ctl_o.shamt = 2'd2;
            OP_ADD8_Q:  ctl_o.shamt = 2'd3;
            OP_ADD_L:   ctl_o.longw = 1'b1;
            OP_ADD_LV:  begin ctl_o.longw = 1'b1; ctl_o.chk = 1'b1; end
            OP_ADD4_L:  begin ctl_o.longw = 1'b1; ctl_o.shamt = 2'd2; end
            OP_ADD8_L:  begin ctl_o.longw = 1'b1; ctl_o.shamt = 2'd3; end
            OP_SUB_Q:   ctl_o.sub = 1'b1;
            OP_SUB_QV:  begin ctl_o.sub = 1'b1; ctl_o.chk = 1'b1; end
            OP_SUB4_Q:  begin ctl_o.sub = 1'b1; ctl_o.shamt = 2'd2; end
            OP_SUB8_Q:  begin ctl_o.sub = 1'b1; ctl_o.shamt = 2'd3; end
            OP_SUB_L:   begin ctl_o.sub = 1'b1; ctl_o.longw = 1'b1; end
            OP_SUB_LV:  begin ctl_o.sub = 1'b1; ctl_o.longw = 1'b1; ctl_o.chk = 1'b1; end
            OP_SUB4_L:  begin ctl_o.sub = 1'b1; ctl_o.longw = 1'b1; ctl_o.shamt = 2'd2; end
            OP_SUB8_L:  begin ctl_o.sub = 1'b1; ctl_o.longw = 1'b1; ctl_o.shamt = 2'd3; end
            OP_CMP_EQ:  begin ctl_o.is_cmp = 1'b1; ctl_o.cmp = CMP_EQ;  end
            OP_CMP_LT:  begin ctl_o.is_cmp = 1'b1; ctl_o.cmp = CMP_LT;  end
            OP_CMP_LE:  begin ctl_o.is_cmp = 1'b1; ctl_o.cmp = CMP_LE;  end
            OP_CMP_ULT: begin ctl_o.is_cmp = 1'b1; ctl_o.cmp = CMP_ULT; end
            OP_CMP_ULE: begin ctl_o.is_cmp = 1'b1; ctl_o.cmp = CMP_ULE; end
            default:    ctl_o.valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/iu_arith.sv
module iu_arith #(
    parameter int W  = 64,
    parameter int LW = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [1:0]   shamt_i,
    input  logic         sub_i,
    input  logic         longw_i,
    output logic [W-1:0] res_o,
    output logic         ovf_o
);

    logic [W-1:0] scaled;
    logic [W-1:0] raw;
    logic [W-1:0] lext;

    assign scaled = a_i << shamt_i;
    assign raw    = sub_i ? (scaled - b_i) : (scaled + b_i);

    generate
        if (LW < W) begin : g_sext
            assign lext = {{(W-LW){raw[LW-1]}}, raw[LW-1:0]};
        end else begin : g_nosext
            assign lext = raw;
        end
    endgenerate

    assign res_o = longw_i ? lext : raw;

    // Sign tests on the unscaled A, as the checked forms never scale.
    logic sa, sb, sr;
    always_comb begin
        if (longw_i) begin
            sa = a_i[LW-1];
            sb = b_i[LW-1];
            sr = res_o[LW-1];
        end else begin
            sa = a_i[W-1];
            sb = b_i[W-1];
            sr = res_o[W-1];
        end
        if (sub_i) ovf_o = (sa ^ sb) & (sa ^ sr);
        else       ovf_o = ~(sa ^ sb) & (sa ^ sr);
    end

endmodule

// File: rtl/iu_compare.sv
module iu_compare
    import iu_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  iu_cmp_e      kind_i,
    output logic         flag_o
);

    logic eq, slt, ult;
    assign eq  = (a_i == b_i);
    assign slt = ($signed(a_i) < $signed(b_i));
    assign ult = (a_i < b_i);

    always_comb begin
        unique case (kind_i)
            CMP_EQ:  flag_o = eq;
            CMP_LT:  flag_o = slt;
            CMP_LE:  flag_o = slt | eq;
            CMP_ULT: flag_o = ult;
            CMP_ULE: flag_o = ult | eq;
            default: flag_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/iu_addcmp.sv
module iu_addcmp
    import iu_pkg::*;
#(
    parameter int W  = 64,
    parameter int LW = 32,
    parameter int RW = 5
) (
    input  logic [W-1:0]  opa_i,
    input  logic [W-1:0]  opb_i,
    input  logic [4:0]    op_i,
    input  logic          trap_en_i,
    input  logic [RW-1:0] dst_i,
    output logic [W-1:0]  res_o,
    output logic          ovf_trap_o,
    output logic [RW-1:0] trap_dst_o
);

    iu_ctl_t      ctl;
    logic [W-1:0] arith_res;
    logic         arith_ovf;
    logic         cmp_flag;

    iu_decode u_dec (
        .op_i  (op_i),
        .ctl_o (ctl)
    );

    iu_arith #(.W(W), .LW(LW)) u_arith (
        .a_i     (opa_i),
        .b_i     (opb_i),
        .shamt_i (ctl.shamt),
        .sub_i   (ctl.sub),
        .longw_i (ctl.longw),
        .res_o   (arith_res),
        .ovf_o   (arith_ovf)
    );

    iu_compare #(.W(W)) u_cmp (
        .a_i    (opa_i),
        .b_i    (opb_i),
        .kind_i (ctl.cmp),
        .flag_o (cmp_flag)
    );

    always_comb begin
        if (!ctl.valid)      res_o = '0;
        else if (ctl.is_cmp) res_o = {{(W-1){1'b0}}, cmp_flag};
        else                 res_o = arith_res;
    end

    assign ovf_trap_o = ctl.valid & ctl.chk & trap_en_i & arith_ovf;
    assign trap_dst_o = ovf_trap_o ? dst_i : '0;

endmodule

// File: rtl/iu_addcmp_chk.sv
module iu_addcmp_chk
    import iu_pkg::*;
#(
    parameter int W  = 64,
    parameter int LW = 32,
    parameter int RW = 5
) (
    input logic [W-1:0]  opa_i,
    input logic [W-1:0]  opb_i,
    input logic [4:0]    op_i,
    input logic          trap_en_i,
    input logic [RW-1:0] dst_i,
    input logic [W-1:0]  res_o,
    input logic          ovf_trap_o,
    input logic [RW-1:0] trap_dst_o
);

    logic is_cmp_op, is_chk_op, is_long_op, is_unused;
    assign is_cmp_op  = (op_i >= 5'd17) && (op_i <= 5'd21);
    assign is_chk_op  = (op_i == OP_ADD_QV) || (op_i == OP_SUB_QV) ||
                        (op_i == OP_ADD_LV) || (op_i == OP_SUB_LV);
    assign is_long_op = ((op_i >= 5'd5) && (op_i <= 5'd8)) ||
                        ((op_i >= 5'd13) && (op_i <= 5'd16));
    assign is_unused  = (op_i == 5'd0) || (op_i >= 5'd22);

    always_comb begin
        // R5: comparison results are a single 0/1 bit
        a_r5_cmp_binary: assert (!is_cmp_op || (res_o[W-1:1] == '0))
            else $error("compare result not 0/1");
        // R10: unchecked forms never trap
        a_r10_unchecked_no_trap: assert (is_chk_op || !ovf_trap_o)
            else $error("trap on unchecked op");
        // R11: trap enable low suppresses the trap
        a_r11_disabled_no_trap: assert (trap_en_i || !ovf_trap_o)
            else $error("trap while disabled");
        // R12: unused codes give zero and no trap
        a_r12_unused_zero: assert (!is_unused || ((res_o == '0) && !ovf_trap_o))
            else $error("unused code produced output");
        // R9: trap tag follows the destination only with a trap
        a_r9_trap_dst: assert (ovf_trap_o ? (trap_dst_o == dst_i) : (trap_dst_o == '0))
            else $error("trap tag mismatch");
        // R4: longword results are sign extended
        a_r4_long_sext: assert (!is_long_op ||
                                (res_o[W-1:LW-1] == '0) || (&res_o[W-1:LW-1]))
            else $error("longword result not sign extended");
    end

endmodule

bind iu_addcmp iu_addcmp_chk #(.W(W), .LW(LW), .RW(RW)) u_chk (
    .opa_i      (opa_i),
    .opb_i      (opb_i),
    .op_i       (op_i),
    .trap_en_i  (trap_en_i),
    .dst_i      (dst_i),
    .res_o      (res_o),
    .ovf_trap_o (ovf_trap_o),
    .trap_dst_o (trap_dst_o)
);

// File: tb/test_iu_addcmp.sv
module test_iu_addcmp;

    localparam int CLK_PERIOD      = 20;
    localparam int WATCHDOG_CYCLES = 150000;
    localparam int SW  = 6;
    localparam int SLW = 3;
    localparam int SRW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int n_run  = 0;
    int n_fail = 0;
    int slot   = 0;
    int cyc    = 0;

    // default-size instance
    logic [63:0] ba, bb, bres;
    logic [4:0]  bop, bdst, btd;
    logic        bten, bovf;

    iu_addcmp i_iu_addcmp (
        .opa_i(ba), .opb_i(bb), .op_i(bop), .trap_en_i(bten), .dst_i(bdst),
        .res_o(bres), .ovf_trap_o(bovf), .trap_dst_o(btd)
    );

    // small instance for exhaustive sweeps
    logic [SW-1:0]  sa, sb, sres;
    logic [4:0]     sop;
    logic [SRW-1:0] sdst, std_o;
    logic           sten, sovf;

    iu_addcmp #(.W(SW), .LW(SLW), .RW(SRW)) i_iu_addcmp_small (
        .opa_i(sa), .opb_i(sb), .op_i(sop), .trap_en_i(sten), .dst_i(sdst),
        .res_o(sres), .ovf_trap_o(sovf), .trap_dst_o(std_o)
    );

    function automatic logic signed [127:0] sx(input logic [63:0] x, input int n);
        logic signed [127:0] t;
        t = $signed({64'd0, x});
        t = t <<< (128 - n);
        return t >>> (128 - n);
    endfunction

    function automatic logic [63:0] msk(input int n);
        return (n >= 64) ? '1 : ((64'd1 << n) - 64'd1);
    endfunction

    // R1: code numbering follows the requirement table
    function automatic string tag_of(input int op);
        int k;
        if (op >= 1 && op <= 16) begin
            k = (op - 1) % 8;
            if (k == 1) return (k >= 4) ? "R8" : ((op >= 9) ? "R7" : "R6");
            if (k == 5) return "R8";
            if (k == 2 || k == 3 || k == 6 || k == 7) return "R3";
            if (k == 4) return "R4";
            return "R2";
        end
        if (op >= 17 && op <= 21) return "R5";
        return "R12";
    endfunction

    task automatic ref_model(input int op, input logic [63:0] a0, input logic [63:0] b0,
                             input int w, input int lw, input bit ten,
                             output logic [63:0] r, output bit v);
        logic [63:0] mask, a, b, s, sa_l;
        logic signed [127:0] ea, eb, e, lim, t;
        int k, sh, n;
        bit isub, islong;
        mask = msk(w);
        a = a0 & mask;
        b = b0 & mask;
        r = '0;
        v = 1'b0;
        if (op >= 1 && op <= 16) begin
            isub   = (op >= 9);
            k      = (op - 1) % 8;
            islong = (k >= 4);
            sh     = ((k % 4) == 2) ? 2 : (((k % 4) == 3) ? 3 : 0);
            sa_l   = (a << sh) & mask;
            s      = (isub ? (sa_l - b) : (sa_l + b)) & mask;
            if (islong) begin
                t = sx(s, lw);
                s = t[63:0] & mask;
            end
            r = s;
            if ((k % 4) == 1 && ten) begin
                n   = islong ? lw : w;
                ea  = sx(a, n);
                eb  = sx(b, n);
                e   = isub ? (ea - eb) : (ea + eb);
                lim = 128'sd1 <<< (n - 1);
                v   = (e >= lim) || (e < -lim);
            end
        end else if (op >= 17 && op <= 21) begin
            ea = sx(a, w);
            eb = sx(b, w);
            case (op)
                17: r = {63'd0, a == b};
                18: r = {63'd0, ea < eb};
                19: r = {63'd0, ea <= eb};
                20: r = {63'd0, a < b};
                default: r = {63'd0, a <= b};
            endcase
        end
    endtask

    task automatic pace();
        if (slot == 0) begin
            @(posedge clk);
            #1;
        end
        slot = (slot + 1) % 4;
    endtask

    task automatic judge(input string nm, input int op, input bit ten,
                         input logic [63:0] a, input logic [63:0] b,
                         input logic [63:0] got_r, input logic [63:0] exp_r,
                         input bit got_v, input bit exp_v,
                         input int got_d, input int exp_d);
        bit chk;
        n_run++;
        chk = (op == 2 || op == 6 || op == 10 || op == 14);
        if (got_r != exp_r) begin
            n_fail++;
            $display("FAIL %s %s op=%0d a=%h b=%h res actual=%h expected=%h",
                     tag_of(op), nm, op, a, b, got_r, exp_r);
        end else if (got_v != exp_v) begin
            n_fail++;
            $display("FAIL %s %s op=%0d a=%h b=%h trap actual=%0d expected=%0d",
                     !chk ? "R10" : (!ten ? "R11" : tag_of(op)),
                     nm, op, a, b, got_v, exp_v);
        end else if (got_d != exp_d) begin
            n_fail++;
            $display("FAIL R9 %s op=%0d a=%h b=%h trap_dst actual=%0d expected=%0d",
                     nm, op, a, b, got_d, exp_d);
        end
    endtask

    task automatic run_small(input int op, input int a, input int b, input bit ten, input int d);
        logic [63:0] er;
        bit ev;
        pace();
        sop = 5'(op); sa = SW'(a); sb = SW'(b); sten = ten; sdst = SRW'(d);
        #1;
        ref_model(op, 64'(a), 64'(b), SW, SLW, ten, er, ev);
        judge("small", op, ten, 64'(a), 64'(b), 64'(sres), er, sovf, ev,
              int'(std_o), ev ? (d % (1 << SRW)) : 0);
        #1;
    endtask

    task automatic run_big(input int op, input logic [63:0] a, input logic [63:0] b,
                           input bit ten, input int d);
        logic [63:0] er;
        bit ev;
        pace();
        bop = 5'(op); ba = a; bb = b; bten = ten; bdst = 5'(d);
        #1;
        ref_model(op, a, b, 64, 32, ten, er, ev);
        judge("big", op, ten, a, b, bres, er, bovf, ev, int'(btd), ev ? (d % 32) : 0);
        #1;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    always @(posedge clk) begin
        if (rst_n) begin
            cyc++;
            if (cyc >= WATCHDOG_CYCLES) begin
                n_fail++;
                $display("FAIL watchdog: run did not complete, cycles actual=%0d expected<%0d",
                         cyc, WATCHDOG_CYCLES);
                summary();
                $finish;
            end
        end
    end

    logic [63:0] corners [13];

    initial begin
        ba = '0; bb = '0; bop = '0; bten = 1'b0; bdst = '0;
        sa = '0; sb = '0; sop = '0; sten = 1'b0; sdst = '0;
        corners[0]  = 64'h0;
        corners[1]  = 64'h1;
        corners[2]  = 64'hFFFF_FFFF_FFFF_FFFF;
        corners[3]  = 64'h8000_0000_0000_0000;
        corners[4]  = 64'h7FFF_FFFF_FFFF_FFFF;
        corners[5]  = 64'h2;
        corners[6]  = 64'h0000_0000_7FFF_FFFF;
        corners[7]  = 64'h0000_0000_8000_0000;
        corners[8]  = 64'h0000_0000_FFFF_FFFF;
        corners[9]  = 64'hFFFF_FFFF_8000_0000;
        corners[10] = 64'h0000_0001_0000_0000;
        corners[11] = 64'h3FFF_FFFF_FFFF_FFFF;
        corners[12] = 64'h2000_0000_0000_0000;
        repeat (3) @(posedge clk);
        #1;
        // R12: idle state with unused code 0 and zero inputs
        n_run++;
        if (bres != '0 || bovf || btd != '0) begin
            n_fail++;
            $display("FAIL R12 idle res actual=%h expected=0 trap actual=%0d expected=0",
                     bres, bovf);
        end
        rst_n = 1'b1;

        // exhaustive sweep on the small build, every code, trap enabled
        for (int op = 0; op < 32; op++)
            for (int a = 0; a < (1 << SW); a++)
                for (int b = 0; b < (1 << SW); b++)
                    run_small(op, a, b, 1'b1, a + b + op);
        // R11: checked forms with trap enable low
        for (int op = 2; op <= 14; op += 4)
            for (int a = 0; a < (1 << SW); a++)
                for (int b = 0; b < (1 << SW); b++)
                    run_small(op, a, b, 1'b0, a);

        // corner operands on the default build
        for (int op = 0; op < 32; op++)
            for (int i = 0; i < 13; i++)
                for (int j = 0; j < 13; j++)
                    run_big(op, corners[i], corners[j], 1'b1, i + j + op);
        for (int i = 0; i < 13; i++)
            for (int j = 0; j < 13; j++) begin
                run_big(2, corners[i], corners[j], 1'b0, 7);
                run_big(10, corners[i], corners[j], 1'b0, 9);
            end
        // random operands on the default build
        for (int k = 0; k < 3000; k++)
            run_big(int'($urandom_range(0, 31)), {$urandom, $urandom}, {$urandom, $urandom},
                    1'($urandom), int'($urandom_range(0, 31)));

        summary();
        $finish;
    end

endmodule